// File: doc/BRIEF.md
# Word-to-Byte Transmit/Receive FIFO Pair

This block sits between a 32-bit register interface and a byte-oriented serial engine. On the transmit side, a 32-bit write is cut into four bytes and queued. The serial engine pulls the bytes one at a time. On the receive side, the engine pushes single bytes. Software reads them back as 32-bit words, and each read takes out up to four of the oldest bytes. A control input picks the byte order for both directions: least significant byte first, or most significant byte first.

Both queues report a byte fill count and simple flags. A programmable threshold flag shows when a queue has reached half or three-quarters of its depth. A write that arrives when the transmit side lacks room for a whole word is dropped and sets a sticky overflow flag. A full receive queue refuses further bytes, and its full flag tells the serial engine to stop receiving. A clear command empties both queues and drops the overflow flag. One interrupt line combines the overflow, receive-not-empty and transmit-empty conditions, each under its own enable.

Top module: `word_byte_fifo`

## Requirements
- R1: After synchronous reset:
  - both fill counts are 0;
  - transmit-empty and transmit-not-full are 1;
  - receive-not-empty, receive-full, overflow and the interrupt are 0.
- R2: A transmit word write that is accepted queues four bytes. With lsb_first_i=1 the bytes leave in the order wdata[7:0], [15:8], [23:16], [31:24]. With lsb_first_i=0 the order is reversed, starting with [31:24].
- R3: Transmit-not-full is 1 exactly when the transmit count is at most DEPTH-4. A write made while it is 0 leaves the queue unchanged and sets overflow. Overflow stays set until a clear.
- R4: tx_byte_o shows the oldest queued transmit byte, or 0 when the queue is empty. A pop removes that byte. A pop on an empty queue has no effect.
- R5: A received byte is appended when the receive count is below DEPTH. At DEPTH, rx_full_o is 1 and pushed bytes are dropped.
- R6: rx_rdata_o packs the oldest min(4, count) receive bytes; positions with no byte read as 0.
  - With lsb_first_i=1 the oldest byte is at [7:0], the next at [15:8], and so on.
  - With lsb_first_i=0 the oldest byte is at [31:24], the next at [23:16], and so on.
  - A read removes those bytes.
- R7: Fill counts are byte counts from 0 to DEPTH (5 bits at DEPTH=16). tx_empty_o is 1 exactly when the transmit count is 0. rx_not_empty_o is 1 exactly when the receive count is nonzero.
- R8: With thresh_sel_i=0 each threshold flag is 1 when its count is at least DEPTH/2. With thresh_sel_i=1 the limit is 3*DEPTH/4.
- R9: A clear empties both queues and clears overflow in the next cycle. It overrides any write, pop, push or read in the same cycle.
- R10: irq_o = (overflow AND err_ie_i) OR (rx_not_empty AND rxne_ie_i) OR (tx_empty AND txe_ie_i).
- R11: Operations on one queue in the same cycle combine:
  - a write and a pop change the transmit count by +3;
  - a push and a read change the receive count by +1 - min(4, count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Empty both queues, clear overflow |
| lsb_first_i | input | 1 | Byte order: 1 low byte first, 0 high byte first |
| thresh_sel_i | input | 1 | Threshold: 0 half, 1 three-quarters |
| tx_wr_i | input | 1 | Transmit word write strobe |
| tx_wdata_i | input | 32 | Transmit word |
| tx_pop_i | input | 1 | Serial engine takes one transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| rx_push_i | input | 1 | Serial engine delivers one byte |
| rx_byte_i | input | 8 | Received byte |
| rx_rd_i | input | 1 | Receive word read strobe |
| rx_rdata_o | output | 32 | Packed receive word |
| tx_count_o | output | 5 | Transmit fill count in bytes |
| rx_count_o | output | 5 | Receive fill count in bytes |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_not_full_o | output | 1 | Room for one more transmit word |
| rx_not_empty_o | output | 1 | Receive queue holds data |
| rx_full_o | output | 1 | Receive queue full; ends reception |
| tx_thr_o | output | 1 | Transmit count at or above threshold |
| rx_thr_o | output | 1 | Receive count at or above threshold |
| overflow_o | output | 1 | Sticky transmit overflow |
| err_ie_i | input | 1 | Overflow interrupt enable |
| rxne_ie_i | input | 1 | Receive-not-empty interrupt enable |
| txe_ie_i | input | 1 | Transmit-empty interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default depth of 16 bytes. At this depth four word writes fill the transmit queue, so the fifth write reaches the overflow path, and sixteen pushes reach the receive-full refusal within a few cycles. Both threshold levels (8 and 12) and the pointer wrap-around at the top of storage come up many times in the random phase. Reads of partial words with 1 to 3 bytes left come up as well, under both byte orders.

// File: rtl/wbf_pkg.sv
package wbf_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_LANES = 4;
    localparam int WORD_W     = BYTE_W * WORD_LANES;
    localparam int LCNT_W     = $clog2(WORD_LANES + 1);

    typedef logic [BYTE_W-1:0]                  byte_t;
    typedef logic [WORD_LANES-1:0][BYTE_W-1:0]  lanes_t;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } order_e;

    typedef enum logic {
        THR_HALF = 1'b0,
        THR_3Q   = 1'b1
    } thr_e;

    typedef struct packed {
        logic err;
        logic rxne;
        logic txe;
    } irq_vec_t;

    // lane 0 is the first byte to leave the queue
    function automatic lanes_t split_word(logic [WORD_W-1:0] w, order_e ord);
        lanes_t r;
        for (int i = 0; i < WORD_LANES; i++) begin
            if (ord == ORDER_LSB)
                r[i] = w[BYTE_W*i +: BYTE_W];
            else
                r[i] = w[BYTE_W*(WORD_LANES-1-i) +: BYTE_W];
        end
        return r;
    endfunction

    // lane 0 is the oldest byte; lanes at or above n read as zero
    function automatic logic [WORD_W-1:0] pack_lanes(lanes_t l, logic [LCNT_W-1:0] n,
                                                     order_e ord);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < WORD_LANES; i++) begin
            if (LCNT_W'(i) < n) begin
                if (ord == ORDER_LSB)
                    w[BYTE_W*i +: BYTE_W] = l[i];
                else
                    w[BYTE_W*(WORD_LANES-1-i) +: BYTE_W] = l[i];
            end
        end
        return w;
    endfunction

    function automatic int unsigned thr_level(int unsigned depth, thr_e s);
        return (s == THR_3Q) ? (depth * 3) / 4 : depth / 2;
    endfunction

endpackage

// File: rtl/wbf_byte_fifo.sv
module wbf_byte_fifo
    import wbf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PUSH_L = 4,
    parameter int POP_L  = 1,
    localparam int PW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PCW   = $clog2(PUSH_L + 1),
    localparam int OCW   = $clog2(POP_L + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clear,
    input  logic [PCW-1:0]               push_cnt,
    input  logic [PUSH_L-1:0][BYTE_W-1:0] push_data,
    input  logic [OCW-1:0]               pop_cnt,
    output logic [POP_L-1:0][BYTE_W-1:0] peek_data,
    output logic [CW-1:0]                count
);

    byte_t          mem [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_L; i++) begin
            if (!clear && (PCW'(i) < push_cnt))
                mem[wr_ptr + PW'(i)] <= push_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_cnt);
            rd_ptr <= rd_ptr + PW'(pop_cnt);
            count  <= count + CW'(push_cnt) - CW'(pop_cnt);
        end
    end

    for (genvar g = 0; g < POP_L; g++) begin : g_peek
        assign peek_data[g] = mem[rd_ptr + PW'(g)];
    end

    assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (int'(count) + int'(push_cnt) <= DEPTH + int'(pop_cnt)));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        !clear |-> (int'(pop_cnt) <= int'(count)));

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

endmodule

// File: rtl/wbf_tx_path.sv
module wbf_tx_path
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  order_e            order,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop,
    output byte_t             head,
    output logic [CW-1:0]     count,
    output logic              empty,
    output logic              not_full,
    output logic              overflow
);

    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - WORD_LANES);

    logic                   accept;
    logic                   pop_ok;
    logic [LCNT_W-1:0]      push_cnt;
    logic [0:0]             pop_cnt;
    lanes_t                 lanes;
    logic [0:0][BYTE_W-1:0] peek;

    assign not_full = (count <= ROOM_LIMIT);
    assign empty    = (count == '0);
    assign accept   = wr && not_full && !clear;
    assign pop_ok   = pop && !empty && !clear;
    assign lanes    = split_word(wdata, order);
    assign push_cnt = accept ? LCNT_W'(WORD_LANES) : '0;
    assign pop_cnt  = pop_ok;
    assign head     = empty ? '0 : peek[0];

    wbf_byte_fifo #(
        .DEPTH  (DEPTH),
        .PUSH_L (WORD_LANES),
        .POP_L  (1)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .push_cnt  (push_cnt),
        .push_data (lanes),
        .pop_cnt   (pop_cnt),
        .peek_data (peek),
        .count     (count)
    );

    always_ff @(posedge clk) begin
        if (rst || clear)
            overflow <= 1'b0;
        else if (wr && !not_full)
            overflow <= 1'b1;
    end

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (overflow && !clear) |=> overflow);

    assert_ovf_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && !not_full && !clear && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/wbf_rx_path.sv
module wbf_rx_path
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  order_e            order,
    input  logic              push,
    input  byte_t             byte_in,
    input  logic              rd,
    output logic [WORD_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              not_empty,
    output logic              full
);

    logic [LCNT_W-1:0] avail;
    logic [LCNT_W-1:0] pop_cnt;
    logic [0:0]        push_cnt;
    lanes_t            peek;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign avail     = (count >= CW'(WORD_LANES)) ? LCNT_W'(WORD_LANES) : LCNT_W'(count);
    assign push_cnt  = push && !full && !clear;
    assign pop_cnt   = (rd && !clear) ? avail : '0;
    assign rdata     = pack_lanes(peek, avail, order);

    wbf_byte_fifo #(
        .DEPTH  (DEPTH),
        .PUSH_L (1),
        .POP_L  (WORD_LANES)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .push_cnt  (push_cnt),
        .push_data (byte_in),
        .pop_cnt   (pop_cnt),
        .peek_data (peek),
        .count     (count)
    );

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (full && push && !rd && !clear) |=> (count == $past(count)));

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        (!not_empty && !push && !clear) |=> !not_empty);

endmodule

// File: rtl/wbf_irq_gen.sv
module wbf_irq_gen
    import wbf_pkg::*;
(
    input  irq_vec_t flags,
    input  irq_vec_t enables,
    output logic     irq
);

    assign irq = |(flags & enables);

endmodule

// File: rtl/word_byte_fifo.sv
module word_byte_fifo
    import wbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clear_i,
    input  logic        lsb_first_i,
    input  logic        thresh_sel_i,
    input  logic        tx_wr_i,
    input  logic [31:0] tx_wdata_i,
    input  logic        tx_pop_i,
    output logic [7:0]  tx_byte_o,
    input  logic        rx_push_i,
    input  logic [7:0]  rx_byte_i,
    input  logic        rx_rd_i,
    output logic [31:0] rx_rdata_o,
    output logic [CW-1:0] tx_count_o,
    output logic [CW-1:0] rx_count_o,
    output logic        tx_empty_o,
    output logic        tx_not_full_o,
    output logic        rx_not_empty_o,
    output logic        rx_full_o,
    output logic        tx_thr_o,
    output logic        rx_thr_o,
    output logic        overflow_o,
    input  logic        err_ie_i,
    input  logic        rxne_ie_i,
    input  logic        txe_ie_i,
    output logic        irq_o
);

    localparam logic [CW-1:0] LVL_HALF = CW'(thr_level(DEPTH, THR_HALF));
    localparam logic [CW-1:0] LVL_3Q   = CW'(thr_level(DEPTH, THR_3Q));

    order_e        order;
    thr_e          thr_sel;
    logic [CW-1:0] level;
    irq_vec_t      flags;
    irq_vec_t      enables;

    assign order   = order_e'(lsb_first_i);
    assign thr_sel = thr_e'(thresh_sel_i);
    assign level   = (thr_sel == THR_3Q) ? LVL_3Q : LVL_HALF;

    wbf_tx_path #(.DEPTH(DEPTH)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear_i),
        .order    (order),
        .wr       (tx_wr_i),
        .wdata    (tx_wdata_i),
        .pop      (tx_pop_i),
        .head     (tx_byte_o),
        .count    (tx_count_o),
        .empty    (tx_empty_o),
        .not_full (tx_not_full_o),
        .overflow (overflow_o)
    );

    wbf_rx_path #(.DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear_i),
        .order     (order),
        .push      (rx_push_i),
        .byte_in   (rx_byte_i),
        .rd        (rx_rd_i),
        .rdata     (rx_rdata_o),
        .count     (rx_count_o),
        .not_empty (rx_not_empty_o),
        .full      (rx_full_o)
    );

    assign tx_thr_o = (tx_count_o >= level);
    assign rx_thr_o = (rx_count_o >= level);

    assign flags   = '{err: overflow_o, rxne: rx_not_empty_o, txe: tx_empty_o};
    assign enables = '{err: err_ie_i, rxne: rxne_ie_i, txe: txe_ie_i};

    wbf_irq_gen u_irq (
        .flags   (flags),
        .enables (enables),
        .irq     (irq_o)
    );

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        !(err_ie_i || rxne_ie_i || txe_ie_i) |-> !irq_o);

    assert_full_stops_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_full_o && !rx_rd_i && !clear_i) |=> rx_full_o);

endmodule

// File: tb/word_byte_fifo_tb_top.sv
`timescale 1ns/100ps
module word_byte_fifo_tb_top;

    localparam int D  = 16;
    localparam int CW = $clog2(D + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 0, lsb = 0, thr = 0;
    logic        wr = 0, pop = 0, push = 0, rd = 0;
    logic [31:0] wdata = '0;
    logic [7:0]  bin = '0;
    logic        err_en = 0, rxne_en = 0, txe_en = 0;

    logic [7:0]    tx_byte;
    logic [31:0]   rx_rdata;
    logic [CW-1:0] tx_count, rx_count;
    logic tx_empty, tx_nf, rx_ne, rx_full, tx_thr, rx_thr, ovf, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit         m_ovf;

    always #2.5 clk = ~clk;

    word_byte_fifo #(.DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .clear_i(clr), .lsb_first_i(lsb), .thresh_sel_i(thr),
        .tx_wr_i(wr), .tx_wdata_i(wdata), .tx_pop_i(pop), .tx_byte_o(tx_byte),
        .rx_push_i(push), .rx_byte_i(bin), .rx_rd_i(rd), .rx_rdata_o(rx_rdata),
        .tx_count_o(tx_count), .rx_count_o(rx_count), .tx_empty_o(tx_empty),
        .tx_not_full_o(tx_nf), .rx_not_empty_o(rx_ne), .rx_full_o(rx_full),
        .tx_thr_o(tx_thr), .rx_thr_o(rx_thr), .overflow_o(ovf),
        .err_ie_i(err_en), .rxne_ie_i(rxne_en), .txe_ie_i(txe_en), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_pack(bit lsbf);
        logic [31:0] w = '0;
        int n = (rxq.size() < 4) ? rxq.size() : 4;
        for (int i = 0; i < n; i++) begin
            if (lsbf) w[8*i +: 8] = rxq[i];
            else      w[8*(3-i) +: 8] = rxq[i];
        end
        return w;
    endfunction

    function automatic bit exp_thr(int cnt, bit sel);
        return cnt >= (sel ? (D * 3) / 4 : D / 2);
    endfunction

    task automatic check_all();
        bit e_txe = (txq.size() == 0);
        bit e_rxne = (rxq.size() != 0);
        chk("R7 tx_count", 32'(tx_count), 32'(txq.size()));
        chk("R7 rx_count", 32'(rx_count), 32'(rxq.size()));
        chk("R7 tx_empty", 32'(tx_empty), 32'(e_txe));
        chk("R7 rx_not_empty", 32'(rx_ne), 32'(e_rxne));
        chk("R3 tx_not_full", 32'(tx_nf), 32'(txq.size() <= D - 4));
        chk("R5 rx_full", 32'(rx_full), 32'(rxq.size() == D));
        chk("R4 tx_byte", 32'(tx_byte), e_txe ? 32'h0 : 32'(txq[0]));
        chk("R6 rx_rdata", rx_rdata, exp_pack(lsb));
        chk("R8 tx_thr", 32'(tx_thr), 32'(exp_thr(txq.size(), thr)));
        chk("R8 rx_thr", 32'(rx_thr), 32'(exp_thr(rxq.size(), thr)));
        chk("R3 overflow", 32'(ovf), 32'(m_ovf));
        chk("R10 irq", 32'(irq), 32'((m_ovf & err_en) | (e_rxne & rxne_en) | (e_txe & txe_en)));
    endtask

    task automatic model_step();
        if (clr) begin
            txq.delete();
            rxq.delete();
            m_ovf = 0;
        end else begin
            int tsz = txq.size();
            int rsz = rxq.size();
            if (pop && tsz > 0) void'(txq.pop_front());
            if (wr) begin
                if (tsz <= D - 4) begin
                    for (int i = 0; i < 4; i++)
                        txq.push_back(lsb ? wdata[8*i +: 8] : wdata[8*(3-i) +: 8]);
                end else m_ovf = 1;
            end
            if (rd) begin
                int n = (rsz < 4) ? rsz : 4;
                for (int i = 0; i < n; i++) void'(rxq.pop_front());
            end
            if (push && rsz < D) rxq.push_back(bin);
        end
    endtask

    task automatic cycle();
        #0.2;
        check_all();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        clr = 0; wr = 0; pop = 0; push = 0; rd = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #0.2;
        // R1 reset state
        chk("R1 tx_count", 32'(tx_count), 0);
        chk("R1 rx_count", 32'(rx_count), 0);
        chk("R1 tx_empty", 32'(tx_empty), 1);
        chk("R1 tx_not_full", 32'(tx_nf), 1);
        chk("R1 rx_not_empty", 32'(rx_ne), 0);
        chk("R1 rx_full", 32'(rx_full), 0);
        chk("R1 overflow", 32'(ovf), 0);
        chk("R1 irq", 32'(irq), 0);
        cycle();

        // R2 low byte first
        lsb = 1; wr = 1; wdata = 32'h44332211; cycle(); idle();
        #0.2; chk("R2 lsb first byte", 32'(tx_byte), 32'h11);
        pop = 1; cycle(); idle();
        #0.2; chk("R2 lsb second byte", 32'(tx_byte), 32'h22);
        pop = 1; cycle(); cycle(); cycle(); idle();
        // R2 high byte first
        lsb = 0; wr = 1; wdata = 32'hA1B2C3D4; cycle(); idle();
        #0.2; chk("R2 msb first byte", 32'(tx_byte), 32'hA1);
        // R11 write + pop together
        wr = 1; pop = 1; wdata = 32'h55667788; cycle(); idle();
        #0.2; chk("R11 tx count +3", 32'(tx_count), 7);
        // fill to 15, then overflow
        wr = 1; cycle(); cycle(); idle();
        #0.2; chk("R3 not_full at 15", 32'(tx_nf), 0);
        wr = 1; wdata = 32'hDEADBEEF; cycle(); idle();
        #0.2; chk("R3 overflow set", 32'(ovf), 1);
        chk("R3 count unchanged", 32'(tx_count), 15);
        err_en = 1; #0.1; chk("R10 irq from overflow", 32'(irq), 1);
        cycle(); cycle();
        #0.2; chk("R3 overflow sticky", 32'(ovf), 1);
        // R9 clear wins over same-cycle ops
        clr = 1; wr = 1; push = 1; bin = 8'h5A; cycle(); idle();
        #0.2; chk("R9 tx emptied", 32'(tx_count), 0);
        chk("R9 overflow cleared", 32'(ovf), 0);
        chk("R9 rx untouched by push", 32'(rx_count), 0);
        err_en = 0;

        // R5 fill receive queue
        lsb = 1; thr = 0;
        for (int i = 0; i < D + 2; i++) begin
            push = 1; bin = 8'(8'hA0 + i); cycle();
        end
        idle();
        #0.2; chk("R5 rx full", 32'(rx_full), 1);
        chk("R5 count capped", 32'(rx_count), D);
        chk("R6 lsb packing", rx_rdata, 32'hA3A2A1A0);
        lsb = 0; #0.1; chk("R6 msb packing", rx_rdata, 32'hA0A1A2A3);
        thr = 1; #0.1; chk("R8 rx thr 3q", 32'(rx_thr), 1);
        rd = 1; cycle(); cycle(); idle();
        #0.2; chk("R8 count 8 below 3q", 32'(rx_thr), 0);
        thr = 0; #0.1; chk("R8 count 8 at half", 32'(rx_thr), 1);
        // R11 push + read together
        rd = 1; push = 1; bin = 8'h77; cycle(); idle();
        #0.2; chk("R11 rx count +1-4", 32'(rx_count), 5);
        rd = 1; cycle(); idle();
        #0.2; chk("R6 partial msb", rx_rdata, 32'h77000000);
        rxne_en = 1; #0.1; chk("R10 irq rxne", 32'(irq), 1);
        rd = 1; cycle(); idle(); rxne_en = 0;
        #0.2; chk("R6 read empties", 32'(rx_count), 0);
        cycle();

        // random phase
        for (int k = 0; k < 4000; k++) begin
            wr    = ($urandom % 100) < 30;
            pop   = ($urandom % 100) < 45;
            push  = ($urandom % 100) < 45;
            rd    = ($urandom % 100) < 20;
            clr   = ($urandom % 100) < 1;
            wdata = $urandom;
            bin   = 8'($urandom);
            if (($urandom % 16) == 0) lsb = ~lsb;
            thr     = ($urandom % 4) == 0;
            err_en  = $urandom % 2;
            rxne_en = $urandom % 2;
            txe_en  = $urandom % 2;
            cycle();
        end
        idle();
        cycle();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule